// File: doc/BRIEF.md
# Interruptible block-copy sequencer

This engine moves a block of bytes from a source region to a destination region, one byte per iteration. It works on three 16-bit working registers: a byte count, a destination pointer and a source pointer. A 2-bit mode chooses the direction in which the pointers step after each byte, and it can hold the source pointer fixed. A fixed source suits draining a single port into a buffer. An optional space prefix moves the source reads into internal or external I/O space. Destination writes always go to memory.

The engine drives a plain bus master: separate read and write strobes, one address, a space code, a write byte and a read byte. It also has a wait input that stretches the read and write phases. The timing is fixed: five setup clocks, then seven clocks per iteration plus the cost of the prefix, then one teardown clock. An interrupt request is accepted only at the boundary between two iterations. When the engine takes one, it pulses an acknowledge instead of continuing and keeps the registers as they stood after the last completed iteration. It also reports the resume address, which is the first byte of the instruction. Software restarts the copy by issuing a new start with those register values.

The engine is a single state machine with these states:

- ST_IDLE: waiting for a start.
- ST_SET_A (2 clocks), ST_SET_B (2 clocks) and ST_SET_C (1 clock): setup.
- ST_RD (2 clocks plus the prefix cost): read the source byte.
- ST_WR (3 clocks): write the destination byte.
- ST_UPD (2 clocks): step the registers.
- ST_TEAR (1 clock): teardown.

Its transitions are:

- IDLE goes to SET_A on start.
- SET_A goes to SET_B, and SET_B goes to SET_C.
- SET_C goes to RD when the count is nonzero, and to TEAR otherwise.
- RD goes to WR, and WR goes to UPD.
- UPD goes to TEAR when the count has reached zero.
- UPD goes to IDLE, with an acknowledge, when an interrupt is pending.
- UPD goes back to RD otherwise.
- TEAR goes to IDLE with done.

Top module: `blkcopy_engine`

## Requirements
- R1: Each iteration reads one byte from the source pointer address in the source space, then writes that byte to the destination pointer address. Write space is always memory (space code 0), and read and write strobes are never high together. The count then drops by one.
- R2: The mode input steps the pointers. Mode bit 0 high means decrement and low means increment. Mode bit 1 high means the source pointer steps, and low means it stays fixed. So mode 3 decrements both pointers, mode 2 increments both, mode 1 decrements only the destination, and mode 0 increments only the destination.
- R3: Prefix 0 (memory source) takes 6 + 7*N clocks from the clock edge that samples start to the edge that raises done, where N is the starting count.
- R4: Prefix 1 reads the source from internal I/O (space code 1) and adds 1 clock to every iteration.
- R5: Prefix 2 reads the source from external I/O (space code 2) and adds 2 clocks plus io_wait_cfg clocks to every iteration. io_wait_cfg is sampled as each read phase begins.
- R6: After each iteration, vflag is high if the count is still nonzero and low once the count has gone from 1 to 0. The engine starts another iteration exactly while vflag is high, and done is raised only with a zero count and vflag low.
- R7: A start with a count of zero performs no bus cycle. It leaves all three registers unchanged, clears vflag and raises done 6 clocks after start.
- R8: An interrupt request that is high in the last clock of an iteration, when that iteration leaves a nonzero count, has four effects. It raises irq_ack for one clock 5 + (7 + prefix cost) clocks after start. It raises no done. It keeps the registers at their stepped values with vflag high. It drives resume_pc to instr_pc minus 1 under prefix 1 or 2, and to instr_pc otherwise.
- R9: An interrupt request never cuts an iteration short. It is ignored during the final iteration, which ends normally with done.
- R10: Each clock with bus_wait high during a read or write phase holds that phase for one more clock and keeps its strobe high.
- R11: After reset, the engine is idle. Both strobes, done, irq_ack, busy and vflag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy; sampled in the idle state |
| mode | input | 2 | Pointer-stepping mode (see R2) |
| prefix | input | 2 | Source space: 0 memory, 1 internal I/O, 2 external I/O |
| instr_pc | input | 16 | Address of the first opcode byte that follows the prefix |
| bc_in | input | 16 | Starting byte count |
| de_in | input | 16 | Starting destination pointer |
| hl_in | input | 16 | Starting source pointer |
| io_wait_cfg | input | 3 | Extra wait clocks for external I/O reads |
| irq | input | 1 | Interrupt request |
| rd_strb | output | 1 | Read strobe |
| wr_strb | output | 1 | Write strobe |
| bus_addr | output | 16 | Bus address |
| bus_space | output | 2 | Space code of the current bus cycle |
| wdata | output | 8 | Write byte |
| rdata | input | 8 | Read byte |
| bus_wait | input | 1 | Stretches the current read or write phase |
| busy | output | 1 | Engine is not idle |
| done | output | 1 | One-clock pulse when the copy completes |
| irq_ack | output | 1 | One-clock pulse when an interrupt is taken |
| bc_out | output | 16 | Current count |
| de_out | output | 16 | Current destination pointer |
| hl_out | output | 16 | Current source pointer |
| vflag | output | 1 | Set while the count is nonzero after an iteration |
| resume_pc | output | 16 | Resume address captured on interrupt |

## Verification
The bench builds the engine with its default parameters. These are a 16-bit address, an 8-bit data byte and a 3-bit wait configuration, which gives a longest read phase of 11 clocks. With these values the bench can:

- reach both pointer extremes;
- run every prefix, including external I/O with zero and nonzero wait settings;
- check the exact clock counts for short blocks.

The interrupt-and-resume sequence, the zero-count start and stretching by the wait input all complete within a few hundred clocks.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_A,
        ST_SET_B,
        ST_SET_C,
        ST_RD,
        ST_WR,
        ST_UPD,
        ST_TEAR
    } blk_state_e;

    localparam logic [1:0] SPC_MEM = 2'd0;
    localparam logic [1:0] SPC_IIO = 2'd1;
    localparam logic [1:0] SPC_EIO = 2'd2;

    localparam int DUR_SET_A = 2;
    localparam int DUR_SET_B = 2;
    localparam int DUR_SET_C = 1;
    localparam int DUR_RD    = 2;
    localparam int DUR_WR    = 3;
    localparam int DUR_UPD   = 2;
    localparam int DUR_TEAR  = 1;
    localparam int EXTRA_IIO = 1;
    localparam int EXTRA_EIO = 2;

    function automatic logic [1:0] space_of(input logic [1:0] pfx);
        case (pfx)
            2'd1:    return SPC_IIO;
            2'd2:    return SPC_EIO;
            default: return SPC_MEM;
        endcase
    endfunction

endpackage

// File: rtl/blkcopy_step.sv
module blkcopy_step #(
    parameter int AW = 16
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] bc,
    input  logic [AW-1:0] de,
    input  logic [AW-1:0] hl,
    output logic [AW-1:0] bc_nx,
    output logic [AW-1:0] de_nx,
    output logic [AW-1:0] hl_nx,
    output logic          more
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic dec;
    logic src_steps;

    assign dec       = mode[0];
    assign src_steps = mode[1];

    always_comb begin
        bc_nx = bc - ONE;
        de_nx = dec ? (de - ONE) : (de + ONE);
        if (src_steps) begin
            hl_nx = dec ? (hl - ONE) : (hl + ONE);
        end else begin
            hl_nx = hl;
        end
        more = (bc_nx != '0);
    end
endmodule

// File: rtl/blkcopy_phase.sv
module blkcopy_phase #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PH_W-1:0] load_val,
    input  logic            stall,
    output logic            expire
);
    logic [PH_W-1:0] cnt_q;

    assign expire = (cnt_q == '0) && !stall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (!stall && cnt_q != '0) begin
            cnt_q <= cnt_q - PH_W'(1);
        end
    end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [1:0]        prefix,
    input  logic [AW-1:0]     instr_pc,
    input  logic [AW-1:0]     bc_in,
    input  logic [AW-1:0]     de_in,
    input  logic [AW-1:0]     hl_in,
    input  logic [WAIT_W-1:0] io_wait_cfg,
    input  logic              irq,
    output logic              rd_strb,
    output logic              wr_strb,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_space,
    output logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     rdata,
    input  logic              bus_wait,
    output logic              busy,
    output logic              done,
    output logic              irq_ack,
    output logic [AW-1:0]     bc_out,
    output logic [AW-1:0]     de_out,
    output logic [AW-1:0]     hl_out,
    output logic              vflag,
    output logic [AW-1:0]     resume_pc
);
    localparam int MAX_PH = DUR_RD + EXTRA_EIO + (1 << WAIT_W) - 1;
    localparam int PH_W   = $clog2(MAX_PH + 1);

    blk_state_e      state_q, state_nx;
    logic [AW-1:0]   bc_q, de_q, hl_q, pc_q, rpc_q;
    logic [1:0]      mode_q, space_q;
    logic [DW-1:0]   byte_q;
    logic            v_q, done_q, ack_q;
    logic [AW-1:0]   bc_nx, de_nx, hl_nx;
    logic            more;
    logic            expire, stall, t_load;
    logic [PH_W-1:0] dur, t_val;

    blkcopy_step #(.AW(AW)) u_step (
        .mode  (mode_q),
        .bc    (bc_q),
        .de    (de_q),
        .hl    (hl_q),
        .bc_nx (bc_nx),
        .de_nx (de_nx),
        .hl_nx (hl_nx),
        .more  (more)
    );

    assign stall  = bus_wait && (state_q == ST_RD || state_q == ST_WR);
    assign t_load = (state_q == ST_IDLE) ? start : expire;
    assign t_val  = dur - PH_W'(1);

    blkcopy_phase #(.PH_W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .stall    (stall),
        .expire   (expire)
    );

    // Next-state and phase-duration selection
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)  state_nx = ST_SET_A;
            ST_SET_A: if (expire) state_nx = ST_SET_B;
            ST_SET_B: if (expire) state_nx = ST_SET_C;
            ST_SET_C: if (expire) state_nx = (bc_q != '0) ? ST_RD : ST_TEAR;
            ST_RD:    if (expire) state_nx = ST_WR;
            ST_WR:    if (expire) state_nx = ST_UPD;
            ST_UPD: begin
                if (expire) begin
                    if (!more)    state_nx = ST_TEAR;
                    else if (irq) state_nx = ST_IDLE;
                    else          state_nx = ST_RD;
                end
            end
            ST_TEAR:  if (expire) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase

        unique case (state_nx)
            ST_SET_A: dur = PH_W'(DUR_SET_A);
            ST_SET_B: dur = PH_W'(DUR_SET_B);
            ST_SET_C: dur = PH_W'(DUR_SET_C);
            ST_RD: begin
                if (space_q == SPC_IIO)
                    dur = PH_W'(DUR_RD + EXTRA_IIO);
                else if (space_q == SPC_EIO)
                    dur = PH_W'(DUR_RD + EXTRA_EIO) + PH_W'(io_wait_cfg);
                else
                    dur = PH_W'(DUR_RD);
            end
            ST_WR:    dur = PH_W'(DUR_WR);
            ST_UPD:   dur = PH_W'(DUR_UPD);
            ST_TEAR:  dur = PH_W'(DUR_TEAR);
            default:  dur = PH_W'(1);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Working registers and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_q    <= '0;
            de_q    <= '0;
            hl_q    <= '0;
            pc_q    <= '0;
            rpc_q   <= '0;
            mode_q  <= '0;
            space_q <= SPC_MEM;
            byte_q  <= '0;
            v_q     <= 1'b0;
            done_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ack_q  <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                bc_q    <= bc_in;
                de_q    <= de_in;
                hl_q    <= hl_in;
                pc_q    <= instr_pc;
                mode_q  <= mode;
                space_q <= space_of(prefix);
                v_q     <= 1'b0;
            end
            if (state_q == ST_RD && expire) byte_q <= rdata;
            if (state_q == ST_UPD && expire) begin
                bc_q <= bc_nx;
                de_q <= de_nx;
                hl_q <= hl_nx;
                v_q  <= more;
                if (more && irq) begin
                    ack_q <= 1'b1;
                    rpc_q <= pc_q - ((space_q != SPC_MEM) ? AW'(1) : AW'(0));
                end
            end
            if (state_q == ST_TEAR && expire) done_q <= 1'b1;
        end
    end

    assign rd_strb   = (state_q == ST_RD);
    assign wr_strb   = (state_q == ST_WR);
    assign bus_addr  = (state_q == ST_RD) ? hl_q : de_q;
    assign bus_space = (state_q == ST_RD) ? space_q : SPC_MEM;
    assign wdata     = byte_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign irq_ack   = ack_q;
    assign bc_out    = bc_q;
    assign de_out    = de_q;
    assign hl_out    = hl_q;
    assign vflag     = v_q;
    assign resume_pc = rpc_q;

    assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strb && wr_strb));

    assert_wr_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strb |-> (bus_space == SPC_MEM));

    assert_hl_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_q[1]) |=> $stable(hl_out));

    assert_done_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bc_out == '0 && !vflag));

    assert_ack_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (vflag && bc_out != '0 && !done));

    assert_ack_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ($past(state_q) == ST_UPD));

    assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wait && rd_strb) |=> rd_strb);
endmodule

// File: tb/blkcopy_engine_test.sv
module blkcopy_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0, prefix = '0;
    logic [15:0] instr_pc = '0, bc_in = '0, de_in = '0, hl_in = '0;
    logic [2:0]  io_wait_cfg = '0;
    logic        irq = 1'b0;
    logic        rd_strb, wr_strb, busy, done, irq_ack, vflag;
    logic [15:0] bus_addr, bc_out, de_out, hl_out, resume_pc;
    logic [1:0]  bus_space;
    logic [7:0]  wdata, rdata;
    logic        bus_wait = 1'b0;

    int n_chk = 0, n_fail = 0;
    int wait_budget = 0;
    logic [23:0] exp_q[$];
    logic [15:0] e_bc, e_de, e_hl;
    logic        wr_prev = 1'b0;

    always #4 clk = ~clk;

    blkcopy_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .prefix(prefix),
        .instr_pc(instr_pc), .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in),
        .io_wait_cfg(io_wait_cfg), .irq(irq), .rd_strb(rd_strb), .wr_strb(wr_strb),
        .bus_addr(bus_addr), .bus_space(bus_space), .wdata(wdata), .rdata(rdata),
        .bus_wait(bus_wait), .busy(busy), .done(done), .irq_ack(irq_ack),
        .bc_out(bc_out), .de_out(de_out), .hl_out(hl_out), .vflag(vflag),
        .resume_pc(resume_pc)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a, input logic [1:0] s);
        return a[7:0] ^ a[15:8] ^ {s, 6'h00} ^ 8'h5A;
    endfunction

    assign rdata = src_byte(bus_addr, bus_space);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: pops one expected write per write cycle
    always @(negedge clk) begin
        if (wr_strb && !wr_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected write", {bus_addr, wdata}, 0);
            end else begin
                logic [23:0] item;
                item = exp_q.pop_front();
                chk({bus_addr, wdata} == item, "R1", "write addr/data",
                    {bus_addr, wdata}, item);
            end
        end
        wr_prev = wr_strb;
    end

    // Wait-input driver (R10)
    always @(negedge clk) begin
        if (rd_strb && wait_budget > 0) begin
            bus_wait = 1'b1;
            wait_budget--;
        end else begin
            bus_wait = 1'b0;
        end
    end

    task automatic run(input string tag, input logic [1:0] md, input logic [1:0] pf,
                       input logic [15:0] bc, input logic [15:0] de, input logic [15:0] hl,
                       input logic [15:0] pc, input logic [2:0] wc, input bit irq_on,
                       input int budget);
        logic [1:0] sp;
        int extra, iters, lat, k;
        bit acked;
        logic [15:0] b, d, h;
        sp    = (pf == 2'd1) ? 2'd1 : (pf == 2'd2) ? 2'd2 : 2'd0;
        extra = (pf == 2'd1) ? 1 : (pf == 2'd2) ? 2 + int'(wc) : 0;
        acked = irq_on && bc > 1;
        iters = acked ? 1 : int'(bc);
        lat   = acked ? 5 + 7 + extra : 6 + (7 + extra) * int'(bc);
        if (bc != 0) lat += budget;
        b = bc; d = de; h = hl;
        for (int i = 0; i < iters; i++) begin
            exp_q.push_back({d, src_byte(h, sp)});
            b = b - 1;
            d = md[0] ? d - 1 : d + 1;
            if (md[1]) h = md[0] ? h - 1 : h + 1;
        end
        e_bc = b; e_de = d; e_hl = h;

        @(negedge clk);
        mode = md; prefix = pf; bc_in = bc; de_in = de; hl_in = hl;
        instr_pc = pc; io_wait_cfg = wc; irq = irq_on; wait_budget = budget;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && !irq_ack && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk(k == lat, tag, "latency", k, lat);
        chk(done == !acked, "R8", {tag, " done"}, done, !acked);
        chk(irq_ack == acked, "R8", {tag, " irq_ack"}, irq_ack, acked);
        chk(bc_out == e_bc, tag, "bc_out", bc_out, e_bc);
        chk(de_out == e_de, "R2", {tag, " de_out"}, de_out, e_de);
        chk(hl_out == e_hl, "R2", {tag, " hl_out"}, hl_out, e_hl);
        chk(vflag == acked, "R6", {tag, " vflag"}, vflag, acked);
        if (acked) begin
            chk(resume_pc == (pc - ((sp != 0) ? 16'd1 : 16'd0)), "R8",
                {tag, " resume_pc"}, resume_pc, pc - ((sp != 0) ? 16'd1 : 16'd0));
        end
        irq = 1'b0;
        @(negedge clk);
        chk(!done && !irq_ack && !busy, "R6", {tag, " pulse ends"},
            {done, irq_ack, busy}, 0);
        chk(exp_q.size() == 0, "R1", {tag, " writes left"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "R11", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_strb && !wr_strb && !done && !irq_ack && !busy && !vflag, "R11",
            "reset state", {rd_strb, wr_strb, done, irq_ack, busy, vflag}, 0);

        run("R3",  2'd3, 2'd0, 16'd3, 16'h8000, 16'h4000, 16'h0100, 3'd0, 1'b0, 0);
        run("R3",  2'd2, 2'd0, 16'd4, 16'hFFFE, 16'h00FE, 16'h0200, 3'd0, 1'b0, 0);
        run("R4",  2'd1, 2'd1, 16'd2, 16'h9000, 16'h0033, 16'h0300, 3'd0, 1'b0, 0);
        run("R5",  2'd0, 2'd2, 16'd3, 16'hA000, 16'h0077, 16'h0400, 3'd5, 1'b0, 0);
        run("R5",  2'd2, 2'd2, 16'd1, 16'h0001, 16'h1234, 16'h0500, 3'd0, 1'b0, 0);
        run("R7",  2'd3, 2'd0, 16'd0, 16'h5555, 16'h6666, 16'h0600, 3'd0, 1'b0, 0);
        // R8: interrupt after first iteration, then resume with the saved state
        run("R8",  2'd2, 2'd1, 16'd5, 16'hB000, 16'hC000, 16'h0701, 3'd0, 1'b1, 0);
        run("R8",  2'd2, 2'd1, e_bc,  e_de,     e_hl,     16'h0701, 3'd0, 1'b0, 0);
        run("R8",  2'd3, 2'd0, 16'd3, 16'hB100, 16'hC100, 16'h0800, 3'd0, 1'b1, 0);
        // R9: interrupt held through the final iteration is ignored
        run("R9",  2'd0, 2'd0, 16'd1, 16'hD000, 16'hE000, 16'h0900, 3'd0, 1'b1, 0);
        run("R10", 2'd2, 2'd0, 16'd2, 16'h7000, 16'h3000, 16'h0A00, 3'd0, 1'b0, 3);

        report();
        $finish;
    end
endmodule